// File: doc/BRIEF.md
# Serial Peripheral Master with Framing Delays

This block is a serial peripheral master with a single active-low select line. It shifts one word out on MOSI while it shifts one word in from MISO. The word length, clock polarity, clock phase and serial clock rate are programmable. The block also controls two timing gaps in each frame. The lead gap runs from the falling edge of the select line to the first serial clock edge. The rest gap runs after each frame, and no new frame can start until it has expired. Both gaps suit slave devices that need settling time around each access.

The host drives the configuration inputs, places a word on `tx_word` and pulses `start`. The block copies the configuration and the word when it accepts the request. It then raises `busy` and runs the frame. When the select line is released, it pulses `done` for one cycle and presents the received word on `rx_word`. `busy` stays high through the rest gap, and start requests that arrive during that time are dropped.

Top module: `spi_delay_master`

## Requirements
- R1: Both directions carry the most significant bit first. The received word is right-aligned in `rx_word`, and bits above the word length read 0.
- R2: The word length is `cfg_len`, limited to the range 8 to 16. A value below 8 acts as 8 and a value above 16 acts as 16.
- R3: While no frame is in progress, `sck` follows `cfg_cpol` with one cycle of register delay. After reset, `sck` is 0.
- R4: With `cfg_cpha`=0, the MSB is on `mosi` from the cycle in which `cs_n` falls. The slave output is sampled on odd (leading) edges and `mosi` moves to the next bit on even (trailing) edges.
- R5: With `cfg_cpha`=1, `mosi` presents bit k on leading edge k+1, counting from the MSB as bit 0, and the slave output is sampled on trailing edges.
- R6: With `cfg_pre`=P, the first `sck` edge comes max(P,1) cycles after `cs_n` falls. `cs_n` falls one cycle after the clock edge that samples an accepted `start`.
- R7: With `cfg_div`=N, consecutive `sck` edges in a frame are N+1 cycles apart. `sck` does not change in any other cycle of a frame, apart from the final return to idle level.
- R8: `cs_n` rises N+1 cycles after the last sampling edge, and `sck` returns to its idle level in the same cycle. In that cycle `done` is high for exactly one cycle, and `rx_word` holds the new word.
- R9: With `cfg_post`=Q, `busy` stays high for max(Q,1) cycles after `cs_n` rises and then falls. `busy` is high from the cycle after acceptance onward.
- R10: A `start` that arrives while `busy` is high is dropped. A `start` that is held high is accepted on the first clock edge at which `busy` is low.
- R11: In reset, `cs_n`=1, `sck`=0, `busy`=0, `done`=0 and `rx_word`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_len | input | 5 | Word length in bits, limited to 8..16 |
| cfg_div | input | 8 | Serial clock half period minus one, in system cycles |
| cfg_pre | input | 8 | Gap from select fall to first clock edge (0 acts as 1) |
| cfg_post | input | 8 | Gap after select rise before the next frame (0 acts as 1) |
| start | input | 1 | Frame request, accepted only while not busy |
| tx_word | input | 16 | Word to send, right-aligned |
| busy | output | 1 | Frame or rest gap in progress |
| done | output | 1 | One-cycle pulse when the frame closes |
| rx_word | output | 16 | Last received word, right-aligned |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The bench runs all four polarity and phase pairings with divider, lead and rest values that include the zero-means-one case. An off-by-one error in any of these counters shifts the `sck`, `cs_n` or `busy` edges by a cycle against the reference. Lengths below 8 and above 16 show whether the length limit is applied: a design without it would clock the wrong number of edges, or would leave stale bits in the upper part of `rx_word`. The bench also pulses `start` in the middle of a frame and holds it high through a rest gap. A design that accepts requests while busy, or one that ends the gap a cycle early, would open an extra frame or open one at the wrong cycle.

// File: rtl/spi_dm_pkg.sv
package spi_dm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CLK,
    ST_TAIL,
    ST_POST
  } seq_state_e;

  // Effective word length: limited to [lo, hi].
  function automatic int unsigned word_len(int unsigned raw, int unsigned lo,
                                           int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // Number of the last sampling edge in a frame (edges counted from 1).
  function automatic int unsigned last_edge(int unsigned len, logic cpha);
    return cpha ? 2 * len : 2 * len - 1;
  endfunction

  // Edge k samples the slave: odd edges for phase 0, even edges for phase 1.
  function automatic logic sample_edge(int unsigned k, logic cpha);
    return cpha ? ((k % 2) == 0) : ((k % 2) == 1);
  endfunction

  // Edge k advances the outgoing bit: even edges for phase 0,
  // odd edges after the first for phase 1.
  function automatic logic shift_edge(int unsigned k, logic cpha);
    return cpha ? (((k % 2) == 1) && (k > 1)) : ((k % 2) == 0);
  endfunction

endpackage

// File: rtl/spi_dm_seq.sv
module spi_dm_seq
  import spi_dm_pkg::*;
#(
  parameter int WORD_MIN = 8,
  parameter int WORD_MAX = 16,
  parameter int TMR_W    = 8,
  parameter int LEN_W    = 5,
  parameter int EDGE_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [TMR_W-1:0] cfg_div,
  input  logic [TMR_W-1:0] cfg_pre,
  input  logic [TMR_W-1:0] cfg_post,
  output logic             busy,
  output logic             cs_n,
  output logic             sck,
  output logic             done,
  output logic             accept,
  output logic             edge_fire,
  output logic             sample_ev,
  output logic             shift_ev,
  output logic             frame_end,
  output logic [LEN_W-1:0] len_sel
);

  seq_state_e       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic [EDGE_W-1:0] ec_q;
  logic [EDGE_W-1:0] edge_idx;
  logic [EDGE_W-1:0] last_idx;
  logic             cpol_q, cpha_q;
  logic [LEN_W-1:0] len_q;
  logic [TMR_W-1:0] div_q, post_q;
  logic             cs_n_q, sck_q, done_q;
  logic             tmr_zero;
  logic             post_end;

  assign tmr_zero  = (tmr_q == '0);
  assign accept    = (state_q == ST_IDLE) && start;
  assign edge_fire = ((state_q == ST_LEAD) || (state_q == ST_CLK)) && tmr_zero;
  assign edge_idx  = (state_q == ST_LEAD) ? EDGE_W'(1) : ec_q + EDGE_W'(1);
  assign last_idx  = EDGE_W'(last_edge(32'(len_q), cpha_q));
  assign sample_ev = edge_fire && sample_edge(32'(edge_idx), cpha_q);
  assign shift_ev  = edge_fire && shift_edge(32'(edge_idx), cpha_q);
  assign frame_end = (state_q == ST_TAIL) && tmr_zero;
  assign post_end  = (state_q == ST_POST) && tmr_zero;
  assign len_sel   = LEN_W'(word_len(32'(cfg_len), WORD_MIN, WORD_MAX));

  assign busy = (state_q != ST_IDLE);
  assign cs_n = cs_n_q;
  assign sck  = sck_q;
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      ec_q    <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      len_q   <= LEN_W'(WORD_MIN);
      div_q   <= '0;
      post_q  <= '0;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sck_q <= cfg_cpol;
          if (accept) begin
            cpol_q  <= cfg_cpol;
            cpha_q  <= cfg_cpha;
            len_q   <= len_sel;
            div_q   <= cfg_div;
            post_q  <= cfg_post;
            ec_q    <= '0;
            tmr_q   <= (cfg_pre == '0) ? '0 : cfg_pre - 1'b1;
            cs_n_q  <= 1'b0;
            state_q <= ST_LEAD;
          end
        end
        ST_LEAD, ST_CLK: begin
          if (edge_fire) begin
            sck_q   <= ~sck_q;
            ec_q    <= edge_idx;
            tmr_q   <= div_q;
            state_q <= (edge_idx == last_idx) ? ST_TAIL : ST_CLK;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_TAIL: begin
          if (frame_end) begin
            cs_n_q  <= 1'b1;
            sck_q   <= cpol_q;
            done_q  <= 1'b1;
            tmr_q   <= (post_q == '0) ? '0 : post_q - 1'b1;
            state_q <= ST_POST;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_POST: begin
          if (post_end) state_q <= ST_IDLE;
          else          tmr_q   <= tmr_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_dm_shift.sv
module spi_dm_shift #(
  parameter int WORD_MAX = 16,
  parameter int LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [LEN_W-1:0]    len,
  input  logic [WORD_MAX-1:0] tx_word,
  input  logic                shift_ev,
  input  logic                sample_ev,
  input  logic                miso,
  output logic                mosi,
  output logic [WORD_MAX-1:0] rx_sh
);

  logic [WORD_MAX-1:0] tx_q;
  logic [WORD_MAX-1:0] rx_q;

  // The outgoing word is left-aligned so that the active MSB is always the top bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= tx_word << (LEN_W'(WORD_MAX) - len);
      rx_q <= '0;
    end else begin
      if (shift_ev)  tx_q <= {tx_q[WORD_MAX-2:0], 1'b0};
      if (sample_ev) rx_q <= {rx_q[WORD_MAX-2:0], miso};
    end
  end

  assign mosi  = tx_q[WORD_MAX-1];
  assign rx_sh = rx_q;

endmodule

// File: rtl/spi_delay_master.sv
module spi_delay_master #(
  parameter int WORD_MIN = 8,
  parameter int WORD_MAX = 16,
  parameter int TMR_W    = 8,
  parameter int LEN_W    = $clog2(WORD_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [TMR_W-1:0]    cfg_div,
  input  logic [TMR_W-1:0]    cfg_pre,
  input  logic [TMR_W-1:0]    cfg_post,
  input  logic                start,
  input  logic [WORD_MAX-1:0] tx_word,
  output logic                busy,
  output logic                done,
  output logic [WORD_MAX-1:0] rx_word,
  output logic                sck,
  output logic                cs_n,
  output logic                mosi,
  input  logic                miso
);

  localparam int EDGE_W = $clog2(2 * WORD_MAX + 1);

  logic             accept;
  logic             edge_fire;
  logic             sample_ev;
  logic             shift_ev;
  logic             frame_end;
  logic [LEN_W-1:0] len_sel;
  logic [WORD_MAX-1:0] rx_sh;
  logic [WORD_MAX-1:0] rx_q;

  spi_dm_seq #(
    .WORD_MIN(WORD_MIN), .WORD_MAX(WORD_MAX), .TMR_W(TMR_W),
    .LEN_W(LEN_W), .EDGE_W(EDGE_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_len(cfg_len),
    .cfg_div(cfg_div), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
    .busy(busy), .cs_n(cs_n), .sck(sck), .done(done),
    .accept(accept), .edge_fire(edge_fire), .sample_ev(sample_ev),
    .shift_ev(shift_ev), .frame_end(frame_end), .len_sel(len_sel)
  );

  spi_dm_shift #(
    .WORD_MAX(WORD_MAX), .LEN_W(LEN_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .len(len_sel),
    .tx_word(tx_word), .shift_ev(shift_ev), .sample_ev(sample_ev),
    .miso(miso), .mosi(mosi), .rx_sh(rx_sh)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_q <= '0;
    else if (frame_end) rx_q <= rx_sh;
  end

  assign rx_word = rx_q;

endmodule

// File: rtl/spi_dm_chk.sv
module spi_dm_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_cpol,
  input logic busy,
  input logic done,
  input logic sck,
  input logic cs_n,
  input logic accept,
  input logic edge_fire
);

  // R3
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !busy && !$past(busy)) |-> (sck == $past(cfg_cpol)));

  // R8
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cs_n && $past(cs_n)));

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cs_n);

  // R7
  sck_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sck)) |-> ($past(edge_fire) || done));

endmodule

bind spi_delay_master spi_dm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .busy(busy),
  .done(done), .sck(sck), .cs_n(cs_n), .accept(accept),
  .edge_fire(edge_fire)
);

// File: tb/spi_delay_master_tb.sv
`timescale 1ns/1ps
module spi_delay_master_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [4:0]  cfg_len = 5'd8;
  logic [7:0]  cfg_div = 8'd0, cfg_pre = 8'd0, cfg_post = 8'd0;
  logic        start = 1'b0;
  logic [15:0] tx_word = '0;
  logic [15:0] slave_word = '0;
  logic        miso = 1'b0;
  logic        busy, done, sck, cs_n, mosi;
  logic [15:0] rx_word;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_falls = 0;
  logic cs_prev = 1'b1;

  // reference model state
  bit m_active = 0;
  int rel = 0, m_D = 1, m_H = 1, m_P = 1, m_L = 8, m_S = 15;
  bit m_cpol = 0, m_cpha = 0, idle_cpol = 0;
  int m_tx = 0, m_slave = 0, exp_rx = 0;

  always #2.5 clk = ~clk;

  spi_delay_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_len(cfg_len), .cfg_div(cfg_div), .cfg_pre(cfg_pre),
    .cfg_post(cfg_post), .start(start), .tx_word(tx_word), .busy(busy),
    .done(done), .rx_word(rx_word), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int clamp_len(int v);
    return (v < 8) ? 8 : ((v > 16) ? 16 : v);
  endfunction

  // model step at each clock edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_active = 0; idle_cpol = 0;
    end else if (m_active) begin
      rel++;
      if (rel == m_D + m_S * m_H + m_P) begin
        m_active = 0;
        idle_cpol = m_cpol;
      end
    end else begin
      idle_cpol = cfg_cpol;
      if (start) begin
        m_active = 1; rel = 0;
        m_cpol = cfg_cpol; m_cpha = cfg_cpha;
        m_L = clamp_len(int'(cfg_len));
        m_S = m_cpha ? 2 * m_L : 2 * m_L - 1;
        m_D = (cfg_pre == 0) ? 1 : int'(cfg_pre);
        m_P = (cfg_post == 0) ? 1 : int'(cfg_post);
        m_H = int'(cfg_div) + 1;
        m_tx = int'(tx_word); m_slave = int'(slave_word);
      end
    end
  end

  // compare on every clock, away from the active edge; drive slave data
  always @(negedge clk) begin
    if (rst_n) begin
      int rcs, edges, shifts, samples;
      bit e_cs, e_done, e_sck;
      if (cs_prev && !cs_n) n_falls++;
      cs_prev = cs_n;
      if (!m_active) begin
        chk("R8", "cs_n idle", cs_n, 1);
        chk("R9", "busy idle", busy, 0);
        chk("R8", "done idle", done, 0);
        chk("R3", "sck idle", sck, idle_cpol);
        miso = 1'b0;
      end else begin
        rcs = m_D + m_S * m_H;
        edges = (rel < m_D) ? 0 : (rel - m_D) / m_H + 1;
        if (edges > m_S) edges = m_S;
        e_cs = (rel >= rcs);
        e_done = (rel == rcs);
        e_sck = e_cs ? m_cpol : (m_cpol ^ edges[0]);
        if (e_done) exp_rx = m_slave & ((1 << m_L) - 1);
        chk("R6 R8", "cs_n", cs_n, e_cs);
        chk("R9", "busy", busy, 1);
        chk("R8", "done", done, e_done);
        chk("R7", "sck", sck, e_sck);
        if (!e_cs) begin
          shifts = m_cpha ? ((edges >= 1) ? (edges + 1) / 2 - 1 : 0) : edges / 2;
          chk(m_cpha ? "R1 R5" : "R1 R4", "mosi", mosi, (m_tx >> (m_L - 1 - shifts)) & 1);
          samples = m_cpha ? edges / 2 : (edges + 1) / 2;
          miso = (samples < m_L) ? 1'((m_slave >> (m_L - 1 - samples)) & 1) : 1'b0;
        end else begin
          miso = 1'b0;
        end
      end
      chk("R1 R2", "rx_word", int'(rx_word), exp_rx);
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  task automatic xfer(bit pol, bit pha, int len, int dv, int pre, int post,
                      int tx, int sl);
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_len = 5'(len);
    cfg_div = 8'(dv); cfg_pre = 8'(pre); cfg_post = 8'(post);
    tx_word = 16'(tx); slave_word = 16'(sl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", "cs_n rst", cs_n, 1);
    chk("R11", "sck rst", sck, 0);
    chk("R11", "busy rst", busy, 0);
    chk("R11", "done rst", done, 0);
    chk("R11", "rx rst", int'(rx_word), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 phase 0, minimum gaps and fastest clock
    xfer(0, 0, 8, 0, 0, 0, 16'h12A5, 16'h003C);
    // R5 phase 1
    xfer(0, 1, 8, 1, 2, 3, 16'h00C3, 16'h0096);
    // R3 idle high, 12-bit word
    xfer(1, 0, 12, 2, 1, 0, 16'hFABC, 16'h0E71);
    // 16-bit word, long lead gap
    xfer(1, 1, 16, 0, 5, 2, 16'h8001, 16'h7FFE);
    // R2 length below range acts as 8
    xfer(0, 1, 3, 1, 1, 1, 16'hAB5A, 16'hFFFF);
    chk("R2", "short len rx", int'(rx_word), 16'h00FF);
    // R2 length above range acts as 16
    xfer(1, 0, 25, 0, 0, 4, 16'hC0DE, 16'hBEEF);
    chk("R2", "long len rx", int'(rx_word), 16'hBEEF);

    // R10: a request in the middle of a frame is dropped
    @(negedge clk);
    cfg_cpol = 0; cfg_cpha = 0; cfg_len = 5'd10; cfg_div = 8'd1;
    cfg_pre = 8'd2; cfg_post = 8'd3; tx_word = 16'h02F0; slave_word = 16'h0155;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    tx_word = 16'hFFFF; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle();

    // R9 R10: start held high across the rest gap opens the next frame at once
    begin
      int base;
      base = n_falls;
      @(negedge clk);
      cfg_cpha = 1; cfg_len = 5'd9; cfg_div = 8'd0; cfg_pre = 8'd0; cfg_post = 8'd6;
      tx_word = 16'h0133; slave_word = 16'h00CC; start = 1'b1;
      while (n_falls < base + 2) @(negedge clk);
      start = 1'b0;
      wait_idle();
    end

    // R10: number of frames equals the number of accepted requests
    chk("R10", "frame count", n_falls, 9);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule